// File: doc/BRIEF.md
# Double-Buffered USB IN Endpoint Packet Buffer

This block holds outgoing packets for one USB IN endpoint. Firmware loads a packet one byte at a time and then pulses a commit strobe. The strobe hands the whole packet to one of two ping-pong buffers when double buffering is on, or to a single buffer when it is off. When the serial engine reports an IN token, the block answers on the next cycle. It either starts a transfer of the oldest committed packet or sends a NAK. In isochronous mode with nothing waiting, it starts a zero-length packet instead. The engine fetches payload bytes by index and pulses a done strobe when the packet is on the wire. That frees the buffer and raises a one-cycle endpoint interrupt.

The packet-ready status bit reads 1 while firmware has no free buffer to load into. The packet-present bit reads 1 while any committed packet waits. The largest packet size is a configuration input, and writes beyond it are dropped. A flush input empties everything. The mode inputs should only change while the block is empty.

Top module: `usb_in_ep_buffer`

## Requirements
- R1: Each byte written with `fw_wr` is appended to the packet being assembled. During a transfer, `tx_data` returns the byte at position `se_idx` of the packet being sent, with position 0 being the first byte written.
- R2: A pulse on `fw_pkt_rdy` commits the assembled packet, and `st_present` reads 1 from the next cycle while any committed packet waits.
- R3: With `cfg_dbl`=1, `st_pkt_rdy` reads 0 the cycle after a commit if the other buffer is free. It reads 1 once both buffers hold committed packets, and returns to 0 after the next send.
- R4: `ep_irq` pulses for exactly one cycle, in the cycle after a `se_done` that ends a committed packet. It never pulses on a commit or on the early clearing of `st_pkt_rdy`.
- R5: A commit with no bytes written yields a committed packet that is sent with `tx_len`=0.
- R6: A token that finds no committed packet answers with `tx_nak`=1 when `cfg_iso`=0. When `cfg_iso`=1 it answers with `tx_start`=1 and `tx_len`=0, and the done of that zero-length packet raises no `ep_irq`.
- R7: With `cfg_dbl`=0, only one packet may be pending. `st_pkt_rdy` stays 1 until it is sent, and further writes are dropped and set `st_overrun`.
- R8: Writes past `cfg_maxp` bytes in one packet, or with no free buffer, are dropped and set the sticky `st_overrun`.
- R9: Committed packets are sent in commit order, and `tx_len` carries each packet's byte count.
- R10: A `flush` pulse discards all committed and partial data and clears `st_overrun`. From the next cycle `st_present`=0 and `st_pkt_rdy`=0.
- R11: `tx_start` or `tx_nak` pulses for one cycle, exactly one cycle after a `se_token` that arrives while no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dbl | input | 1 | Enable two ping-pong buffers |
| cfg_iso | input | 1 | Isochronous endpoint: send zero-length packet when empty |
| cfg_maxp | input | LW | Largest packet size in bytes (1 to DEPTH) |
| flush | input | 1 | Discard all buffered data |
| fw_wr | input | 1 | Firmware byte write strobe |
| fw_data | input | 8 | Firmware byte |
| fw_pkt_rdy | input | 1 | Firmware commit strobe (write of the ready bit) |
| st_pkt_rdy | output | 1 | Ready bit readback: no free buffer to load |
| st_present | output | 1 | A committed packet is waiting |
| st_overrun | output | 1 | Sticky dropped-write flag |
| ep_irq | output | 1 | One-cycle packet-sent interrupt |
| se_token | input | 1 | IN token seen by the serial engine |
| se_done | input | 1 | Serial engine finished the current packet |
| se_idx | input | AW | Byte index requested by the serial engine |
| tx_start | output | 1 | Transfer begins with length tx_len |
| tx_nak | output | 1 | No data: answer with NAK |
| tx_len | output | LW | Byte count of the packet being sent |
| tx_data | output | 8 | Byte at se_idx of the packet being sent |

## Verification
Every status output and every answer to the engine comes from one register stage. So `st_pkt_rdy`, `st_present`, `st_overrun`, `ep_irq`, `tx_start`, `tx_nak` and `tx_len` change on the first rising edge after the stimulus. Only `tx_data` follows `se_idx` without a clock. The bench drives each strobe for one cycle starting at a falling edge and samples at the following falling edge, which lies half a period after the edge that captured the result. Pulse widths are proven by sampling again one falling edge later. Payload bytes are sampled one time unit after `se_idx` changes.

// File: rtl/usb_inbuf_pkg.sv
package usb_inbuf_pkg;
    localparam int NBUF = 2;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/ep_pkt_ram.sv
module ep_pkt_ram
    import usb_inbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/usb_in_ep_buffer.sv
module usb_in_ep_buffer
    import usb_inbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dbl,
    input  logic          cfg_iso,
    input  logic [LW-1:0] cfg_maxp,
    input  logic          flush,
    input  logic          fw_wr,
    input  byte_t         fw_data,
    input  logic          fw_pkt_rdy,
    output logic          st_pkt_rdy,
    output logic          st_present,
    output logic          st_overrun,
    output logic          ep_irq,
    input  logic          se_token,
    input  logic          se_done,
    input  logic [AW-1:0] se_idx,
    output logic          tx_start,
    output logic          tx_nak,
    output logic [LW-1:0] tx_len,
    output byte_t         tx_data
);
    typedef struct packed {
        logic [NBUF-1:0][LW-1:0] len;
        logic [NBUF-1:0]         full;
        logic                    wsel;
        logic                    head;
        logic                    rdy;
        logic                    ovr;
        logic                    busy;
        logic                    real_pkt;
        logic                    irq;
        logic                    start;
        logic                    nak;
        logic [LW-1:0]           txlen;
    } st_t;

    st_t st_d, st_q;
    logic [NBUF-1:0]  we;
    logic [AW-1:0]    waddr;
    byte_t            rd [NBUF];

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        st_d.start = 1'b0;
        st_d.nak   = 1'b0;
        we         = '0;
        waddr      = st_q.len[st_q.wsel][AW-1:0];

        // Engine finished: release the head buffer
        if (se_done && st_q.busy) begin
            st_d.busy = 1'b0;
            if (st_q.real_pkt) begin
                st_d.full[st_q.head] = 1'b0;
                st_d.len[st_q.head]  = '0;
                st_d.irq             = 1'b1;
                if (cfg_dbl) st_d.head = ~st_q.head;
            end
        end

        // Firmware byte load
        if (fw_wr) begin
            if (st_q.full[st_q.wsel] || st_q.len[st_q.wsel] >= cfg_maxp ||
                st_q.len[st_q.wsel] >= LW'(DEPTH)) begin
                st_d.ovr = 1'b1;
            end else begin
                we[st_q.wsel]       = 1'b1;
                st_d.len[st_q.wsel] = st_q.len[st_q.wsel] + 1'b1;
            end
        end

        // Firmware commit
        if (fw_pkt_rdy && !st_q.full[st_q.wsel]) begin
            st_d.full[st_q.wsel] = 1'b1;
            if (cfg_dbl) st_d.wsel = ~st_q.wsel;
        end

        // IN token from the engine
        if (se_token && !st_q.busy) begin
            if (st_q.full[st_q.head]) begin
                st_d.start    = 1'b1;
                st_d.busy     = 1'b1;
                st_d.real_pkt = 1'b1;
                st_d.txlen    = st_q.len[st_q.head];
            end else if (cfg_iso) begin
                st_d.start    = 1'b1;
                st_d.busy     = 1'b1;
                st_d.real_pkt = 1'b0;
                st_d.txlen    = '0;
            end else begin
                st_d.nak = 1'b1;
            end
        end

        st_d.rdy = st_d.full[st_d.wsel];

        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        ep_pkt_ram #(.DEPTH(DEPTH)) u_ram (
            .clk   (clk),
            .we    (we[g]),
            .waddr (waddr),
            .wdata (fw_data),
            .raddr (se_idx),
            .rdata (rd[g])
        );
    end

    assign st_pkt_rdy = st_q.rdy;
    assign st_present = |st_q.full;
    assign st_overrun = st_q.ovr;
    assign ep_irq     = st_q.irq;
    assign tx_start   = st_q.start;
    assign tx_nak     = st_q.nak;
    assign tx_len     = st_q.txlen;
    assign tx_data    = rd[st_q.head];

    // R4
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> $past(se_done));
    // R11
    answer_after_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start || tx_nak) |-> $past(se_token));
    // R6
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && tx_nak));
    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!st_present && !st_pkt_rdy && !st_overrun));
    // R7
    rdy_needs_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_pkt_rdy |-> st_present);
endmodule

// File: tb/sim_usb_in_ep_buffer.sv
module sim_usb_in_ep_buffer;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_dbl = 1'b1, cfg_iso = 1'b0;
    logic [LW-1:0] cfg_maxp = LW'(4);
    logic flush = 1'b0, fw_wr = 1'b0, fw_pkt_rdy = 1'b0;
    logic [7:0] fw_data = '0;
    logic se_token = 1'b0, se_done = 1'b0;
    logic [AW-1:0] se_idx = '0;
    logic st_pkt_rdy, st_present, st_overrun, ep_irq, tx_start, tx_nak;
    logic [LW-1:0] tx_len;
    logic [7:0] tx_data;

    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    usb_in_ep_buffer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl), .cfg_iso(cfg_iso),
        .cfg_maxp(cfg_maxp), .flush(flush), .fw_wr(fw_wr), .fw_data(fw_data),
        .fw_pkt_rdy(fw_pkt_rdy), .st_pkt_rdy(st_pkt_rdy), .st_present(st_present),
        .st_overrun(st_overrun), .ep_irq(ep_irq), .se_token(se_token),
        .se_done(se_done), .se_idx(se_idx), .tx_start(tx_start), .tx_nak(tx_nak),
        .tx_len(tx_len), .tx_data(tx_data)
    );

    // {op[1:0] (0 idle, 1 byte write, 2 commit), data[7:0], expected rdy, expected present}
    localparam logic [11:0] TBL [6] = '{
        {2'd1, 8'h11, 1'b0, 1'b0},
        {2'd1, 8'h22, 1'b0, 1'b0},
        {2'd2, 8'h00, 1'b0, 1'b1},
        {2'd1, 8'h33, 1'b0, 1'b1},
        {2'd2, 8'h00, 1'b1, 1'b1},
        {2'd1, 8'h44, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        fw_wr = 1'b1; fw_data = b; @(negedge clk); fw_wr = 1'b0;
    endtask
    task automatic commit();
        fw_pkt_rdy = 1'b1; @(negedge clk); fw_pkt_rdy = 1'b0;
    endtask
    task automatic token();
        se_token = 1'b1; @(negedge clk); se_token = 1'b0;
    endtask
    task automatic done();
        se_done = 1'b1; @(negedge clk); se_done = 1'b0;
    endtask
    task automatic do_flush();
        flush = 1'b1; @(negedge clk); flush = 1'b0;
    endtask
    task automatic byte_at(input int i, input int exp, input string req);
        se_idx = AW'(i); #1; chk(req, tx_data, exp);
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R2 reset present", st_present, 0);
        chk("R3 reset rdy", st_pkt_rdy, 0);
        chk("R8 reset overrun", st_overrun, 0);
        chk("R4 reset irq", ep_irq, 0);
        chk("R11 reset start", tx_start, 0);

        // R2 R3 R4 R8: table walk, double-buffered, max 4 bytes
        for (int i = 0; i < 6; i++) begin
            case (TBL[i][11:10])
                2'd1:    wr(TBL[i][9:2]);
                2'd2:    commit();
                default: @(negedge clk);
            endcase
            chk("R3 rdy step", st_pkt_rdy, int'(TBL[i][1]));
            chk("R2 present step", st_present, int'(TBL[i][0]));
            chk("R4 no irq on load", ep_irq, 0);
        end
        chk("R8 overrun with no free buffer", st_overrun, 1);

        // R9 R1 R11: first packet goes out first
        token();
        chk("R11 start after token", tx_start, 1);
        chk("R11 no nak", tx_nak, 0);
        chk("R9 first len", tx_len, 2);
        byte_at(0, 8'h11, "R1 byte 0");
        byte_at(1, 8'h22, "R1 byte 1");
        @(negedge clk);
        chk("R11 start one cycle", tx_start, 0);
        done();
        chk("R4 irq on sent", ep_irq, 1);
        chk("R3 rdy clears after send", st_pkt_rdy, 0);
        chk("R2 still present", st_present, 1);
        @(negedge clk);
        chk("R4 irq one cycle", ep_irq, 0);
        token();
        chk("R9 second len", tx_len, 1);
        byte_at(0, 8'h33, "R9 second byte");
        done();
        chk("R4 irq second", ep_irq, 1);
        chk("R2 empty after sends", st_present, 0);

        // R10
        do_flush();
        chk("R10 flush clears overrun", st_overrun, 0);
        wr(8'h55); commit(); do_flush();
        chk("R10 flush present", st_present, 0);
        chk("R10 flush rdy", st_pkt_rdy, 0);
        token();
        chk("R6 nak when empty", tx_nak, 1);
        chk("R6 no start when empty", tx_start, 0);

        // R5 zero-length commit
        commit();
        chk("R5 present", st_present, 1);
        token();
        chk("R5 start", tx_start, 1);
        chk("R5 len", tx_len, 0);
        done();
        chk("R5 irq", ep_irq, 1);

        // R6 isochronous empty
        cfg_iso = 1'b1;
        token();
        chk("R6 iso start", tx_start, 1);
        chk("R6 iso len", tx_len, 0);
        done();
        chk("R6 iso no irq", ep_irq, 0);
        cfg_iso = 1'b0;

        // R7 single buffer
        cfg_dbl = 1'b0;
        wr(8'h66); commit();
        chk("R7 rdy held", st_pkt_rdy, 1);
        wr(8'h77);
        chk("R7 write dropped", st_overrun, 1);
        chk("R7 rdy still held", st_pkt_rdy, 1);
        token();
        chk("R7 len", tx_len, 1);
        byte_at(0, 8'h66, "R7 byte");
        done();
        chk("R7 rdy clears on sent", st_pkt_rdy, 0);
        chk("R7 empty", st_present, 0);

        // R8 size limit
        do_flush();
        cfg_maxp = LW'(2);
        wr(8'h01); wr(8'h02);
        chk("R8 no overrun at limit", st_overrun, 0);
        wr(8'h03);
        chk("R8 overrun past limit", st_overrun, 1);
        commit(); token();
        chk("R8 len capped", tx_len, 2);
        byte_at(1, 8'h02, "R8 last kept byte");
        done();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule